// File: doc/BRIEF.md
# DS3 Transmit Overhead Inserter

This block builds the outgoing DS3 M-frame as a serial bit stream. Payload bits arrive one at a time from a terminal-side source over a valid/ready handshake. Before every run of 84 payload bits the block places one overhead bit, so the line carries a sequence of 85-bit groups. Each overhead bit is an X, P, M, F or C bit chosen by the group's place in the frame. The P value is the parity of the payload in the previous M-frame. A control input selects C-bit parity mode or M13 mode, and this choice decides what goes into the C-bit slots.

The line side gets one bit per emitted slot, marked by a one-cycle line clock enable, and a frame reference pulse on the first bit of each M-frame. The source must hold `pay_data` stable while `pay_valid` is high and `pay_ready` is low. `pay_ready` depends only on the frame position, never on `pay_valid`. The line side has no back-pressure: an overhead bit is sent in its slot whether or not payload is waiting. A payload slot waits, and sends nothing, until the source offers a bit.

Five active-low force inputs each inject one error. They can corrupt the F bit, an arbitrary overhead bit, the P pair, the C-parity triple, or the far-end block error triple. Only a falling edge counts, so holding an input low has no further effect.

Top module: `ds3_tx_ohi`

## Requirements
- R1: A frame position counts 0..4759. A slot whose position modulo 85 is 0 is an overhead slot; every other slot is a payload slot. `pay_ready` is low in overhead slots and high in payload slots. An overhead slot is emitted in the cycle it is current. A payload slot is emitted only in a cycle where `pay_valid` and `pay_ready` are both high, and it carries `pay_data`. Each emitted bit shows on `line_bit` with `line_ce` high one clock later, and the payload keeps its order.
- R2: Group g is floor(position/85). Its index within the subframe is g mod 8 and its subframe is floor(g/8), from 0 to 6; the second X bit is therefore at position 680. The bit at group index 0 is an X bit (value 1) in subframes 0 and 1, a P bit in subframes 2 and 3, and an M bit in subframes 4, 5 and 6 with values 0, 1, 0. The F bits at group indices 1, 3, 5 and 7 are 1, 0, 0, 1.
- R3: Both P bits equal the XOR of all payload bits of the previous M-frame. They are 0 in the first frame after reset.
- R4: C bits sit at group indices 2, 4 and 6. With `cbit_mode`=1, the C bits of subframe 2 equal the P value, the C bits of subframe 3 (far-end block error bits) are 1, and all other C bits are 1. With `cbit_mode`=0, every C bit is 0.
- R5: `frame_ref` is high for one clock, together with the `line_ce` that carries position 0 of an M-frame, and is low at all other times.
- R6: `oh_open` is high exactly when the current slot is a payload slot. A falling edge of `force_oh_n` sampled while `oh_open` is high inverts the next overhead bit emitted. A falling edge sampled while `oh_open` is low has no effect.
- R7: A falling edge of `force_frm_n` inverts the next F bit emitted.
- R8: A falling edge of `force_pp_n` inverts both P bits of the M-frame that starts after the edge.
- R9: A falling edge of `force_cp_n` inverts the three subframe-2 C bits of the next M-frame, but only while `cbit_mode`=1. In M13 mode the edge is ignored.
- R10: A falling edge of `force_febe_n` sends the three subframe-3 C bits of the next M-frame as 0, but only while `cbit_mode`=1. In M13 mode the edge is ignored.
- R11: Each falling edge produces exactly one error, however long the input stays low. When several error sources hit the same bit, that bit is inverted once.
- R12: During and straight after reset, `line_ce`, `frame_ref`, `oh_open` and `pay_ready` are 0, and the first emitted bit is position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cbit_mode | input | 1 | 1 = C-bit parity mode, 0 = M13 mode |
| pay_valid | input | 1 | Payload bit offered |
| pay_ready | output | 1 | Payload slot open |
| pay_data | input | 1 | Payload bit |
| line_bit | output | 1 | Outgoing DS3 bit |
| line_ce | output | 1 | Line clock enable, high when `line_bit` is new |
| frame_ref | output | 1 | Pulse on position 0 of each M-frame |
| oh_open | output | 1 | Window in which `force_oh_n` is accepted |
| force_oh_n | input | 1 | Falling edge corrupts the next overhead bit |
| force_frm_n | input | 1 | Falling edge corrupts the next F bit |
| force_pp_n | input | 1 | Falling edge corrupts the next P pair |
| force_cp_n | input | 1 | Falling edge corrupts the next C-parity triple |
| force_febe_n | input | 1 | Falling edge zeroes the next block-error triple |

## Verification
Two injections can land on the same bit. The overhead-error request and the framing-error request can both target one F bit, and the overhead request can also fall on a P bit that the P-pair force already inverts. The bench pulls `force_oh_n` and `force_frm_n` low together in the payload slots just before an F-bit group. The expected bit is inverted only once, and both pending requests must be used up by that single bit. Random pulses on all five force inputs, mixed with pay_valid gaps, also make the overhead and P-pair corruptions meet. A reference model in the bench judges each line bit.

// File: rtl/ds3_ohi_pkg.sv
package ds3_ohi_pkg;
  localparam int NUM_FORCE = 5;
  localparam int FI_OH   = 0;
  localparam int FI_FRM  = 1;
  localparam int FI_PP   = 2;
  localparam int FI_CP   = 3;
  localparam int FI_FEBE = 4;
endpackage

// File: rtl/ds3_ohi_pos.sv
module ds3_ohi_pos #(
  parameter int PAY_BITS   = 84,
  parameter int GRP_PER_SF = 8,
  parameter int SF_PER_MF  = 7,
  localparam int OFS_W = $clog2(PAY_BITS + 1),
  localparam int GRP_W = $clog2(GRP_PER_SF),
  localparam int SF_W  = $clog2(SF_PER_MF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic             ofs_zero,
  output logic [GRP_W-1:0] grp,
  output logic [SF_W-1:0]  sf
);
  logic [OFS_W-1:0] ofs;

  assign ofs_zero = (ofs == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs <= '0;
      grp <= '0;
      sf  <= '0;
    end else if (step) begin
      if (ofs == OFS_W'(PAY_BITS)) begin
        ofs <= '0;
        if (grp == GRP_W'(GRP_PER_SF - 1)) begin
          grp <= '0;
          sf  <= (sf == SF_W'(SF_PER_MF - 1)) ? '0 : sf + SF_W'(1);
        end else begin
          grp <= grp + GRP_W'(1);
        end
      end else begin
        ofs <= ofs + OFS_W'(1);
      end
    end
  end
endmodule

// File: rtl/ds3_ohi_parity.sv
module ds3_ohi_parity (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic din,
  input  logic frame_start,
  output logic p_val
);
  logic acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= 1'b0;
      p_val <= 1'b0;
    end else if (frame_start) begin
      p_val <= acc;
      acc   <= 1'b0;
    end else if (take) begin
      acc <= acc ^ din;
    end
  end
endmodule

// File: rtl/ds3_ohi_fall.sv
module ds3_ohi_fall #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_n,
  output logic [N-1:0] fall
);
  for (genvar i = 0; i < N; i++) begin : g_edge
    logic prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= lvl_n[i];
    end
    assign fall[i] = prev & ~lvl_n[i];
  end
endmodule

// File: rtl/ds3_tx_ohi.sv
module ds3_tx_ohi
  import ds3_ohi_pkg::*;
#(
  parameter int PAY_BITS   = 84,
  parameter int GRP_PER_SF = 8,
  parameter int SF_PER_MF  = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cbit_mode,
  input  logic pay_valid,
  output logic pay_ready,
  input  logic pay_data,
  output logic line_bit,
  output logic line_ce,
  output logic frame_ref,
  output logic oh_open,
  input  logic force_oh_n,
  input  logic force_frm_n,
  input  logic force_pp_n,
  input  logic force_cp_n,
  input  logic force_febe_n
);
  localparam int GRP_W   = $clog2(GRP_PER_SF);
  localparam int SF_W    = $clog2(SF_PER_MF);
  localparam int P_SF_A  = 2;
  localparam int P_SF_B  = 3;
  localparam int CP_SF   = 2;
  localparam int FB_SF   = 3;
  localparam int M_ONE_SF = SF_PER_MF - 2;

  logic             ofs_zero;
  logic [GRP_W-1:0] grp;
  logic [SF_W-1:0]  sf;
  logic             hs, step, p_val;
  logic             is_first, is_f, is_c, frame_start;
  logic             base, inv;
  logic [NUM_FORCE-1:0] fall;
  logic             pend_oh, pend_f;
  logic             pp_pend, pp_act, cp_pend, cp_act, fb_pend, fb_act;

  assign pay_ready = !ofs_zero;
  assign oh_open   = !ofs_zero;
  assign hs        = pay_valid & pay_ready;
  assign step      = ofs_zero | hs;

  ds3_ohi_pos #(
    .PAY_BITS(PAY_BITS), .GRP_PER_SF(GRP_PER_SF), .SF_PER_MF(SF_PER_MF)
  ) u_pos (
    .clk(clk), .rst_n(rst_n), .step(step),
    .ofs_zero(ofs_zero), .grp(grp), .sf(sf)
  );

  ds3_ohi_parity u_par (
    .clk(clk), .rst_n(rst_n), .take(hs), .din(pay_data),
    .frame_start(frame_start), .p_val(p_val)
  );

  ds3_ohi_fall #(.N(NUM_FORCE)) u_fall (
    .clk(clk), .rst_n(rst_n),
    .lvl_n({force_febe_n, force_cp_n, force_pp_n, force_frm_n, force_oh_n}),
    .fall(fall)
  );

  assign is_first    = ofs_zero && (grp == '0);
  assign is_f        = ofs_zero && grp[0];
  assign is_c        = ofs_zero && !grp[0] && (grp != '0);
  assign frame_start = is_first && (sf == '0);

  // overhead value before any injected error
  always_comb begin
    base = 1'b0;
    if (!ofs_zero) begin
      base = pay_data;
    end else if (is_first) begin
      if (sf < SF_W'(P_SF_A))       base = 1'b1;
      else if (sf <= SF_W'(P_SF_B)) base = p_val;
      else                          base = (sf == SF_W'(M_ONE_SF));
    end else if (is_f) begin
      base = (grp == GRP_W'(1)) || (grp == GRP_W'(GRP_PER_SF - 1));
    end else if (cbit_mode) begin
      if (sf == SF_W'(CP_SF))      base = p_val;
      else if (sf == SF_W'(FB_SF)) base = !fb_act;
      else                         base = 1'b1;
    end
  end

  // coincident sources are ORed: a bit is inverted at most once
  assign inv = (pend_oh & ofs_zero)
             | (pend_f & is_f)
             | (pp_act & is_first & (sf == SF_W'(P_SF_A) || sf == SF_W'(P_SF_B)))
             | (cp_act & cbit_mode & is_c & (sf == SF_W'(CP_SF)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_oh <= 1'b0;
      pend_f  <= 1'b0;
      pp_pend <= 1'b0;
      pp_act  <= 1'b0;
      cp_pend <= 1'b0;
      cp_act  <= 1'b0;
      fb_pend <= 1'b0;
      fb_act  <= 1'b0;
    end else begin
      if (fall[FI_OH] && !ofs_zero) pend_oh <= 1'b1;
      else if (ofs_zero)            pend_oh <= 1'b0;
      if (fall[FI_FRM])             pend_f <= 1'b1;
      else if (is_f)                pend_f <= 1'b0;
      if (frame_start) begin
        pp_act  <= pp_pend;
        pp_pend <= fall[FI_PP];
        cp_act  <= cp_pend;
        cp_pend <= fall[FI_CP] & cbit_mode;
        fb_act  <= fb_pend;
        fb_pend <= fall[FI_FEBE] & cbit_mode;
      end else begin
        pp_pend <= pp_pend | fall[FI_PP];
        cp_pend <= cp_pend | (fall[FI_CP] & cbit_mode);
        fb_pend <= fb_pend | (fall[FI_FEBE] & cbit_mode);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_bit  <= 1'b0;
      line_ce   <= 1'b0;
      frame_ref <= 1'b0;
    end else begin
      line_ce   <= step;
      frame_ref <= frame_start;
      if (step) line_bit <= base ^ inv;
    end
  end
endmodule

// File: rtl/ds3_tx_ohi_chk.sv
module ds3_tx_ohi_chk (
  input logic clk,
  input logic rst_n,
  input logic pay_valid,
  input logic pay_ready,
  input logic line_ce,
  input logic frame_ref,
  input logic oh_open
);
  // R1: an accepted payload bit reaches the line one clock later
  assert_payload_emits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_valid && pay_ready) |=> line_ce);

  // R1: an overhead slot is always emitted, with no payload wait
  assert_overhead_emits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pay_ready |=> line_ce);

  // R1: an overhead slot lasts a single cycle
  assert_overhead_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pay_ready |=> pay_ready);

  // R5: frame reference only rides on an emitted bit
  assert_ref_with_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ref |-> line_ce);

  // R5: frame reference is a single-cycle pulse
  assert_ref_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ref |=> !frame_ref);

  // R6: window closes when the overhead slot is due
  assert_window_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pay_ready |-> !oh_open);

  // R12: reset clears the line side
  assert_reset_quiet_R12: assert property (@(posedge clk)
    !rst_n |=> (!line_ce && !frame_ref));
endmodule

bind ds3_tx_ohi ds3_tx_ohi_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pay_valid(pay_valid), .pay_ready(pay_ready),
  .line_ce(line_ce), .frame_ref(frame_ref), .oh_open(oh_open)
);

// File: tb/tb_ds3_tx_ohi.sv
module tb_ds3_tx_ohi;
  localparam int CLK_PERIOD = 10;
  localparam int GRP_LEN = 85;
  localparam int SF_LEN  = 680;
  localparam int MF_LEN  = 4760;
  localparam int LAST_FRAME = 9;

  logic clk = 1'b0;
  logic rst_n, cbit_mode, pay_valid, pay_data;
  logic pay_ready, line_bit, line_ce, frame_ref, oh_open;
  logic [4:0] frc_n;

  int checks = 0, errors = 0, cycles = 0;

  ds3_tx_ohi dut (
    .clk(clk), .rst_n(rst_n), .cbit_mode(cbit_mode),
    .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data),
    .line_bit(line_bit), .line_ce(line_ce), .frame_ref(frame_ref), .oh_open(oh_open),
    .force_oh_n(frc_n[0]), .force_frm_n(frc_n[1]), .force_pp_n(frc_n[2]),
    .force_cp_n(frc_n[3]), .force_febe_n(frc_n[4])
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench model state
  int  bpos = 0, frame = 0;
  bit  m_acc = 0, m_pval = 0;
  bit  m_pend_oh = 0, m_pend_f = 0;
  bit  m_pp_pend = 0, m_pp_act = 0, m_cp_pend = 0, m_cp_act = 0, m_fb_pend = 0, m_fb_act = 0;
  bit  m_prev [5] = '{1, 1, 1, 1, 1};
  bit  exp_ce = 0, exp_first = 0;
  bit  q_bit [$];
  int  q_tag [$];
  int  hold [5] = '{0, 0, 0, 0, 0};

  function automatic string tag_name(int t);
    case (t)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";  10: return "R10"; 11: return "R11"; default: return "R12";
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (pos %0d frame %0d)",
               req, what, act, exp, bpos, frame);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // sample outputs left by the previous edge
  task automatic observe();
    chk(pay_ready == (bpos % GRP_LEN != 0), "R1", "pay_ready", pay_ready, bpos % GRP_LEN != 0);
    chk(oh_open == (bpos % GRP_LEN != 0), "R6", "oh_open", oh_open, bpos % GRP_LEN != 0);
    chk(line_ce == exp_ce, "R1", "line_ce", line_ce, exp_ce);
    chk(frame_ref == exp_first, "R5", "frame_ref", frame_ref, exp_first);
    if (line_ce && exp_ce) begin
      if (q_bit.size() == 0) chk(0, "R1", "queue empty", 0, 1);
      else begin
        bit eb;
        int et;
        eb = q_bit.pop_front();
        et = q_tag.pop_front();
        chk(line_bit == eb, tag_name(et), "line_bit", line_bit, eb);
      end
    end
  endtask

  // pick inputs for the coming edge and advance the model
  task automatic drive_and_model();
    int ofs, g, s, tag, nsrc;
    bit f [5];
    bit hs, step, first, is_f, is_c, base, inv, s_oh, s_f, s_pp, s_cp, fb_hit;
    bit cm;
    cm = !(frame == 5 || frame == 6);
    ofs = bpos % GRP_LEN;
    g = (bpos / GRP_LEN) % 8;
    s = bpos / SF_LEN;

    // random force pulses in selected frames
    for (int i = 0; i < 5; i++) begin
      if (frc_n[i] == 1'b0) begin
        hold[i]--;
        if (hold[i] <= 0) frc_n[i] = 1'b1;
      end else if ((frame == 0 || frame == 4 || frame == 6 || frame == 8) &&
                   $urandom_range(0, 3999) == 0) begin
        frc_n[i] = 1'b0;
        hold[i] = int'($urandom_range(1, 600));
      end
    end
    // directed: overhead and framing requests on the same F bit (R11)
    if (frame == 1 && bpos == 8 * GRP_LEN + 10) begin
      frc_n[0] = 1'b0; frc_n[1] = 1'b0; hold[0] = 3; hold[1] = 3;
    end
    // directed: overhead request outside the window is ignored (R6)
    if (frame == 2 && bpos == 20 * GRP_LEN) begin
      frc_n[0] = 1'b0; hold[0] = 1;
    end
    // directed: P force held low for over a frame gives one error (R8, R11)
    if (frame == 2 && bpos == 50) begin
      frc_n[2] = 1'b0; hold[2] = 9000;
    end
    // directed: C-parity and block-error forces in C mode (R9, R10)
    if (frame == 3 && bpos == 200) begin
      frc_n[3] = 1'b0; frc_n[4] = 1'b0; hold[3] = 5; hold[4] = 5;
    end
    // directed: same forces in M13 mode must be ignored (R9, R10)
    if (frame == 5 && bpos == 1500) begin
      frc_n[3] = 1'b0; frc_n[4] = 1'b0; hold[3] = 5; hold[4] = 5;
    end

    cbit_mode = cm;
    pay_valid = ($urandom_range(0, 3) != 0);
    pay_data  = 1'($urandom_range(0, 1));

    for (int i = 0; i < 5; i++) f[i] = m_prev[i] && !frc_n[i];
    hs = pay_valid && ofs != 0;
    step = (ofs == 0) || hs;
    first = (ofs == 0) && g == 0;
    is_f = (ofs == 0) && (g % 2 == 1);
    is_c = (ofs == 0) && (g % 2 == 0) && g != 0;

    base = 0; tag = 1; fb_hit = 0;
    if (ofs != 0) base = pay_data;
    else if (first) begin
      if (s < 2) begin base = 1; tag = 2; end
      else if (s <= 3) begin base = m_pval; tag = 3; end
      else begin base = (s == 5); tag = 2; end
    end else if (is_f) begin
      base = (g == 1 || g == 7); tag = 2;
    end else begin
      tag = 4;
      if (cm) begin
        if (s == 2) base = m_pval;
        else if (s == 3) begin base = !m_fb_act; fb_hit = m_fb_act; end
        else base = 1;
      end else begin
        base = 0;
        if (s == 2) tag = 9;
        if (s == 3) tag = 10;
      end
    end
    s_oh = m_pend_oh && ofs == 0;
    s_f  = m_pend_f && is_f;
    s_pp = m_pp_act && first && (s == 2 || s == 3);
    s_cp = m_cp_act && cm && is_c && s == 2;
    inv = s_oh | s_f | s_pp | s_cp;
    nsrc = int'(s_oh) + int'(s_f) + int'(s_pp) + int'(s_cp);
    if (nsrc > 1) tag = 11;
    else if (s_oh) tag = 6;
    else if (s_f) tag = 7;
    else if (s_pp) tag = 8;
    else if (s_cp) tag = 9;
    else if (fb_hit) tag = 10;

    if (step) begin
      q_bit.push_back(base ^ inv);
      q_tag.push_back(tag);
    end
    exp_ce = step;
    exp_first = step && bpos == 0;

    if (hs) m_acc ^= pay_data;
    if (f[0] && ofs != 0) m_pend_oh = 1; else if (ofs == 0) m_pend_oh = 0;
    if (f[1]) m_pend_f = 1; else if (is_f) m_pend_f = 0;
    if (first && s == 0) begin
      m_pval = m_acc; m_acc = 0;
      m_pp_act = m_pp_pend; m_pp_pend = f[2];
      m_cp_act = m_cp_pend; m_cp_pend = f[3] && cm;
      m_fb_act = m_fb_pend; m_fb_pend = f[4] && cm;
    end else begin
      m_pp_pend |= f[2];
      m_cp_pend |= f[3] && cm;
      m_fb_pend |= f[4] && cm;
    end
    for (int i = 0; i < 5; i++) m_prev[i] = frc_n[i];
    if (step) begin
      if (bpos == MF_LEN - 1) begin bpos = 0; frame++; end
      else bpos++;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cbit_mode = 1'b1; pay_valid = 1'b0; pay_data = 1'b0; frc_n = '1;
    repeat (3) @(negedge clk);
    // R12: quiet outputs while reset is held
    chk(line_ce == 0, "R12", "line_ce in reset", line_ce, 0);
    chk(frame_ref == 0, "R12", "frame_ref in reset", frame_ref, 0);
    chk(oh_open == 0, "R12", "oh_open in reset", oh_open, 0);
    chk(pay_ready == 0, "R12", "pay_ready in reset", pay_ready, 0);
    rst_n = 1'b1;
    while (frame < LAST_FRAME) begin
      observe();
      drive_and_model();
      @(negedge clk);
    end
    observe();
    pay_valid = 1'b0;
    finish_run();
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        errors++; checks++;
        $display("FAIL R1 watchdog actual=%0d expected=%0d", cycles, 190000);
        finish_run();
      end
    end
  end
endmodule